// File: doc/BRIEF.md
# UART Register Front End with Switchable Receive Buffer

This block is the bus-facing half of a serial port. A processor reaches it over a simple 32-bit register bus with a 12-bit byte address. Registers are chosen by word index, which is the byte address shifted right by two. Characters from a serial receiver arrive as 12-bit words. The low 8 bits are the character and the upper 4 bits are error status. These words are queued in a receive buffer. Bytes written by software go out to a transmitter as a one-cycle valid pulse that carries the byte.

A bit in the line-control register sets the receive buffer depth. With the bit set, the buffer holds 16 entries. With it clear, the buffer is a single holding register. Changing that bit empties the buffer. Reading a character moves its error bits into a status register, which software can clear by writing to it.

The block keeps the receive and transmit interrupt sources, masks them, and drives one interrupt line. The baud divisors, the low-power divisor, the control, level-select and DMA control registers are only stored and read back. A parameter chooses one of two sets of identification bytes that the block returns from the top of its address window.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the flag register (index 6) reads 0x90, control (index 12) reads 0x300, level select (index 13) reads 0x12, the mask (index 14) and raw status (index 15) read 0, and irq is low. Flag bits are: bit 4 receive empty, bit 5 transmit full (always 0), bit 6 receive full, bit 7 transmit empty (always 1).
- R2: The stored registers read back what was written, truncated to their widths: low-power divisor (index 8) 8 bits, integer divisor (index 9) 16 bits, fractional divisor (index 10) 6 bits, DMA control (index 18) 3 bits. Writes to the flag register have no effect. Unmapped indices such as 2 and 17 read as 0.
- R3: Byte addresses 0xFE0 to 0xFFC return one identification byte per word, selected by (address − 0xFE0) >> 2. With ID_SET=0 the bytes are 11 10 14 00 0D F0 05 B1. With ID_SET=1 they are 11 00 18 01 0D F0 05 B1.
- R4: A write to index 0 drives tx_valid high for exactly one cycle, starting the cycle after the write, with tx_byte equal to write data bits 7:0. The same write sets raw status bit 5, which then stays set.
- R5: With line-control bit 4 set, the buffer accepts 16 words. At 16 words rx_ready goes low and the receive-full flag is set. Words offered while rx_ready is low are dropped.
- R6: With line-control bit 4 clear, the buffer holds one word. The receive-full flag is set and rx_ready goes low after one word.
- R7: A read of index 0 returns the oldest word in bits 11:0 (error bits 11:8, character bits 7:0), removes it, and clears receive-full. Removing the last word sets receive-empty. A read of index 0 while the buffer is empty returns 0 and changes no state.
- R8: Each read that removes a word copies that word's bits 11:8 into the receive status register (index 1). A write to index 1 clears it to 0.
- R9: Raw status bit 4 is set when a received word brings the count to the trigger count (RX_TRIGGER, default 1). It is cleared when a data read leaves the count at one below the trigger.
- R10: The masked status (index 16) equals raw status AND mask, and irq is high exactly when the masked status is nonzero.
- R11: A line-control write that changes bit 4 empties the buffer: receive-empty is set, receive-full is cleared, and raw bit 4 is cleared. A line-control write that leaves bit 4 unchanged keeps the buffer contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address; bits 11:2 select the register |
| bus_rd | input | 1 | Read strobe; a data read removes a word at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| rx_valid | input | 1 | A received word is offered |
| rx_word | input | 12 | Received word: error bits 11:8, character 7:0 |
| rx_ready | output | 1 | Buffer has room; a word offered while low is dropped |
| tx_valid | output | 1 | One-cycle pulse carrying a byte to transmit |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Combined interrupt |

## Verification
The bench fills the buffer to exactly 16 words and then offers one more. A design with an off-by-one capacity would either keep the extra word, making it appear in the read order, or refuse the sixteenth. It reads the buffer empty and then reads once more. A design that pops on an empty read would return stale data or overwrite the error status. It switches the buffer mode both with and without a change to bit 4. A design that flushes on every line-control write, or never flushes, would show the wrong flags, a stale receive interrupt, or lost data. It also pushes two words against a trigger of one and pops them one at a time. This catches a receive interrupt that clears too early or sticks after the buffer is empty.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam int IDX_W   = 10;
    localparam int DATA_W  = 8;
    localparam int ERR_W   = 4;
    localparam int WORD_W  = DATA_W + ERR_W;

    // register word indices
    localparam logic [IDX_W-1:0] RI_DATA  = 10'd0;
    localparam logic [IDX_W-1:0] RI_ESTAT = 10'd1;
    localparam logic [IDX_W-1:0] RI_FLAG  = 10'd6;
    localparam logic [IDX_W-1:0] RI_LPDIV = 10'd8;
    localparam logic [IDX_W-1:0] RI_IBAUD = 10'd9;
    localparam logic [IDX_W-1:0] RI_FBAUD = 10'd10;
    localparam logic [IDX_W-1:0] RI_LINE  = 10'd11;
    localparam logic [IDX_W-1:0] RI_CTRL  = 10'd12;
    localparam logic [IDX_W-1:0] RI_LEVEL = 10'd13;
    localparam logic [IDX_W-1:0] RI_MASK  = 10'd14;
    localparam logic [IDX_W-1:0] RI_RAW   = 10'd15;
    localparam logic [IDX_W-1:0] RI_MSKD  = 10'd16;
    localparam logic [IDX_W-1:0] RI_DMA   = 10'd18;
    localparam logic [IDX_W-1:0] RI_IDBASE = 10'h3F8;

    // stored register widths
    localparam int W_LPDIV = 8;
    localparam int W_IBAUD = 16;
    localparam int W_FBAUD = 6;
    localparam int W_LINE  = 8;
    localparam int W_CTRL  = 16;
    localparam int W_LEVEL = 6;
    localparam int W_INT   = 11;
    localparam int W_DMA   = 3;

    localparam logic [W_CTRL-1:0]  CTRL_RST  = 16'h0300;
    localparam logic [W_LEVEL-1:0] LEVEL_RST = 6'h12;

    localparam int LINE_BUF_EN = 4;
    localparam int INT_RX      = 4;
    localparam int INT_TX      = 5;
    localparam int FLG_RXE     = 4;
    localparam int FLG_TXF     = 5;
    localparam int FLG_RXF     = 6;
    localparam int FLG_TXE     = 7;

    typedef struct packed {
        logic [W_LPDIV-1:0] lpdiv;
        logic [W_IBAUD-1:0] ibaud;
        logic [W_FBAUD-1:0] fbaud;
        logic [W_LINE-1:0]  line;
        logic [W_CTRL-1:0]  ctrl;
        logic [W_LEVEL-1:0] level;
        logic [W_INT-1:0]   mask;
        logic [W_DMA-1:0]   dma;
    } cfg_regs_t;

endpackage

// File: rtl/uart_id_table.sv
module uart_id_table #(
    parameter int ID_SET = 0
) (
    input  logic [2:0] sel,
    output logic [7:0] id_byte
);

    generate
        if (ID_SET == 1) begin : g_set_b
            always_comb begin
                case (sel)
                    3'd0:    id_byte = 8'h11;
                    3'd1:    id_byte = 8'h00;
                    3'd2:    id_byte = 8'h18;
                    3'd3:    id_byte = 8'h01;
                    3'd4:    id_byte = 8'h0D;
                    3'd5:    id_byte = 8'hF0;
                    3'd6:    id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end else begin : g_set_a
            always_comb begin
                case (sel)
                    3'd0:    id_byte = 8'h11;
                    3'd1:    id_byte = 8'h10;
                    3'd2:    id_byte = 8'h14;
                    3'd3:    id_byte = 8'h00;
                    3'd4:    id_byte = 8'h0D;
                    3'd5:    id_byte = 8'hF0;
                    3'd6:    id_byte = 8'h05;
                    default: id_byte = 8'hB1;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 12,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_en,
    input  logic              flush,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic              ready,
    output logic              accepted,
    output logic              taken,
    output logic [WORD_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_next
);

    typedef struct packed {
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t        st_d, st_q;
    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [CNT_W-1:0]  cap;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PTR_W-1:0] slot_of(input logic [PTR_W-1:0] p,
                                                 input logic [CNT_W-1:0] c);
        logic [PTR_W:0] s;
        s = {1'b0, p} + (PTR_W+1)'(c);
        if (int'(s) >= DEPTH) s = s - (PTR_W+1)'(DEPTH);
        return s[PTR_W-1:0];
    endfunction

    assign cap      = buf_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign ready    = st_q.count < cap;
    assign accepted = push && ready;
    assign taken    = pop && (st_q.count != '0) && !flush;

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        if (flush) begin
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else if (taken) begin
            st_d.rd_ptr = ptr_inc(st_q.rd_ptr);
            st_d.count  = st_q.count - 1'b1;
        end
        if (accepted) begin
            mem_d[slot_of(st_d.rd_ptr, st_d.count)] = push_word;
            st_d.count = st_d.count + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    assign head       = mem_q[st_q.rd_ptr];
    assign count      = st_q.count;
    assign count_next = st_d.count;

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int ID_SET     = 0,
    parameter int RX_DEPTH   = 16,
    parameter int RX_TRIGGER = 1,
    localparam int CNT_W     = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              irq
);

    typedef struct packed {
        cfg_regs_t         cfg;
        logic [ERR_W-1:0]  estat;
        logic              rxe;
        logic              rxf;
        logic              rx_int;
        logic              tx_int;
        logic              tx_valid;
        logic [DATA_W-1:0] tx_byte;
    } top_state_t;

    localparam top_state_t RESET_STATE = '{
        cfg: '{lpdiv: '0, ibaud: '0, fbaud: '0, line: '0,
               ctrl: CTRL_RST, level: LEVEL_RST, mask: '0, dma: '0},
        estat: '0, rxe: 1'b1, rxf: 1'b0, rx_int: 1'b0, tx_int: 1'b0,
        tx_valid: 1'b0, tx_byte: '0
    };

    top_state_t        st_d, st_q;
    logic [IDX_W-1:0]  idx;
    logic              flush, pop_req;
    logic              f_ready, f_acc, f_taken;
    logic [WORD_W-1:0] f_head;
    logic [CNT_W-1:0]  f_count, f_count_next;
    logic [7:0]        id_byte;
    logic [W_INT-1:0]  raw, masked;
    logic [7:0]        flags;
    logic              buf_en_next;
    logic              unused_bits;

    // names brought out for the bound checker
    logic              rx_empty_q, rx_full_q, buf_en_q;
    logic [ERR_W-1:0]  estat_q;

    assign idx         = bus_addr[11:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:16]};
    assign pop_req     = bus_rd && (idx == RI_DATA);
    assign flush       = bus_wr && (idx == RI_LINE) &&
                         (bus_wdata[LINE_BUF_EN] != st_q.cfg.line[LINE_BUF_EN]);

    uart_rx_fifo #(
        .DEPTH (RX_DEPTH),
        .WORD_W(WORD_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_en    (st_q.cfg.line[LINE_BUF_EN]),
        .flush     (flush),
        .push      (rx_valid),
        .push_word (rx_word),
        .pop       (pop_req),
        .ready     (f_ready),
        .accepted  (f_acc),
        .taken     (f_taken),
        .head      (f_head),
        .count     (f_count),
        .count_next(f_count_next)
    );

    uart_id_table #(.ID_SET(ID_SET)) u_id (
        .sel    (idx[2:0]),
        .id_byte(id_byte)
    );

    // next-state computation
    always_comb begin
        st_d          = st_q;
        st_d.tx_valid = 1'b0;

        if (bus_wr) begin
            case (idx)
                RI_DATA: begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_byte  = bus_wdata[DATA_W-1:0];
                    st_d.tx_int   = 1'b1;
                end
                RI_ESTAT: st_d.estat     = '0;
                RI_LPDIV: st_d.cfg.lpdiv = bus_wdata[W_LPDIV-1:0];
                RI_IBAUD: st_d.cfg.ibaud = bus_wdata[W_IBAUD-1:0];
                RI_FBAUD: st_d.cfg.fbaud = bus_wdata[W_FBAUD-1:0];
                RI_LINE:  st_d.cfg.line  = bus_wdata[W_LINE-1:0];
                RI_CTRL:  st_d.cfg.ctrl  = bus_wdata[W_CTRL-1:0];
                RI_LEVEL: st_d.cfg.level = bus_wdata[W_LEVEL-1:0];
                RI_MASK:  st_d.cfg.mask  = bus_wdata[W_INT-1:0];
                RI_DMA:   st_d.cfg.dma   = bus_wdata[W_DMA-1:0];
                default: ;
            endcase
        end

        if (f_taken) st_d.estat = f_head[WORD_W-1:DATA_W];

        buf_en_next = st_d.cfg.line[LINE_BUF_EN];
        st_d.rxe    = (f_count_next == '0);
        st_d.rxf    = (f_count_next == (buf_en_next ? CNT_W'(RX_DEPTH) : CNT_W'(1)));

        if (f_taken && (int'(f_count) - 1 == RX_TRIGGER - 1)) st_d.rx_int = 1'b0;
        if (flush && !f_acc)                                  st_d.rx_int = 1'b0;
        if (f_acc && (int'(f_count_next) == RX_TRIGGER))      st_d.rx_int = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    // status vectors
    always_comb begin
        raw         = '0;
        raw[INT_RX] = st_q.rx_int;
        raw[INT_TX] = st_q.tx_int;
        masked      = raw & st_q.cfg.mask;
        flags          = '0;
        flags[FLG_RXE] = st_q.rxe;
        flags[FLG_TXF] = 1'b0;
        flags[FLG_RXF] = st_q.rxf;
        flags[FLG_TXE] = 1'b1;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (idx >= RI_IDBASE) begin
            bus_rdata = 32'(id_byte);
        end else begin
            case (idx)
                RI_DATA:  bus_rdata = (f_count != '0) ? 32'(f_head) : 32'd0;
                RI_ESTAT: bus_rdata = 32'(st_q.estat);
                RI_FLAG:  bus_rdata = 32'(flags);
                RI_LPDIV: bus_rdata = 32'(st_q.cfg.lpdiv);
                RI_IBAUD: bus_rdata = 32'(st_q.cfg.ibaud);
                RI_FBAUD: bus_rdata = 32'(st_q.cfg.fbaud);
                RI_LINE:  bus_rdata = 32'(st_q.cfg.line);
                RI_CTRL:  bus_rdata = 32'(st_q.cfg.ctrl);
                RI_LEVEL: bus_rdata = 32'(st_q.cfg.level);
                RI_MASK:  bus_rdata = 32'(st_q.cfg.mask);
                RI_RAW:   bus_rdata = 32'(raw);
                RI_MSKD:  bus_rdata = 32'(masked);
                RI_DMA:   bus_rdata = 32'(st_q.cfg.dma);
                default:  bus_rdata = 32'd0;
            endcase
        end
    end

    assign rx_ready   = f_ready;
    assign tx_valid   = st_q.tx_valid;
    assign tx_byte    = st_q.tx_byte;
    assign irq        = |masked;

    assign rx_empty_q = st_q.rxe;
    assign rx_full_q  = st_q.rxf;
    assign buf_en_q   = st_q.cfg.line[LINE_BUF_EN];
    assign estat_q    = st_q.estat;

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [11:0]      bus_addr,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [31:0]      bus_wdata,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic [7:0]       tx_byte,
    input logic             rx_empty,
    input logic             rx_full,
    input logic             buf_en,
    input logic [3:0]       estat,
    input logic [CNT_W-1:0] count
);

    logic wr_data, wr_estat, wr_flag;
    assign wr_data  = bus_wr && (bus_addr[11:2] == 10'd0);
    assign wr_estat = bus_wr && (bus_addr[11:2] == 10'd1);
    assign wr_flag  = bus_wr && (bus_addr[11:2] == 10'd6);

    // R4: a data write produces the byte on the next cycle
    a_r4_tx_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));

    // R4: no transmit pulse without a preceding data write
    a_r4_tx_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(wr_data));

    // R5: the buffer never holds more than its depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    // R5: a refused word leaves the buffer unchanged
    a_r5_refused_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready && !bus_rd && !bus_wr) |=> $stable(count));

    // R6: single-entry mode never holds more than one word
    a_r6_single_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en |-> (int'(count) <= 1));

    // R7: empty and full are never reported together
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_empty && rx_full));

    // R8: writing the error status register clears it
    a_r8_estat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_estat && !bus_rd) |=> (estat == 4'd0));

    // R2: a flag register write changes no flag
    a_r2_flag_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !rx_valid && !bus_rd) |=> ($stable(rx_empty) && $stable(rx_full)));

endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .tx_byte  (tx_byte),
    .rx_empty (rx_empty_q),
    .rx_full  (rx_full_q),
    .buf_en   (buf_en_q),
    .estat    (estat_q),
    .count    (f_count)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_alt;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_word = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_byte;
    logic        rx_ready_alt, tx_valid_alt, irq_alt;
    logic [7:0]  tx_byte_alt;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regfile #(.ID_SET(0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_word(rx_word), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
    );

    uart_regfile #(.ID_SET(1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(1'b0),
        .bus_wr(1'b0), .bus_wdata(bus_wdata), .bus_rdata(rdata_alt),
        .rx_valid(1'b0), .rx_word(rx_word), .rx_ready(rx_ready_alt),
        .tx_valid(tx_valid_alt), .tx_byte(tx_byte_alt), .irq(irq_alt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 12'(idx * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic push(input logic [11:0] w);
        @(negedge clk);
        rx_word  = w;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h018, d); chk("R1 flags", d, 32'h90);
        rd(12'h030, d); chk("R1 control", d, 32'h300);
        rd(12'h034, d); chk("R1 level", d, 32'h12);
        rd(12'h038, d); chk("R1 mask", d, 32'h0);
        rd(12'h03C, d); chk("R1 raw", d, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 tx_valid", 32'(tx_valid), 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(9, 32'hFFFF_1234);  rd(12'h024, d); chk("R2 ibaud", d, 32'h1234);
        wr(10, 32'hFF);        rd(12'h028, d); chk("R2 fbaud width", d, 32'h3F);
        wr(8, 32'h1A5);        rd(12'h020, d); chk("R2 lpdiv", d, 32'hA5);
        wr(18, 32'hFF);        rd(12'h048, d); chk("R2 dma width", d, 32'h7);
        wr(6, 32'h0);          rd(12'h018, d); chk("R2 flag write ignored", d, 32'h90);
        rd(12'h008, d); chk("R2 unmapped 2", d, 32'h0);
        rd(12'h044, d); chk("R2 unmapped 17", d, 32'h0);
    endtask

    task automatic t_id();
        logic [7:0] exp_a [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        logic [7:0] exp_b [8] = '{8'h11, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_addr = 12'hFE0 + 12'(i * 4);
            #1;
            chk($sformatf("R3 id set0 byte %0d", i), bus_rdata, 32'(exp_a[i]));
            chk($sformatf("R3 id set1 byte %0d", i), rdata_alt, 32'(exp_b[i]));
        end
    endtask

    task automatic t_single();
        logic [31:0] d;
        chk("R6 ready when empty", 32'(rx_ready), 32'h1);
        push(12'h5A1);
        chk("R6 ready low after one", 32'(rx_ready), 32'h0);
        rd(12'h018, d); chk("R6 full after one", d, 32'hC0);
        push(12'h222);
        rd(12'h000, d); chk("R7 oldest word", d, 32'h5A1);
        rd(12'h004, d); chk("R8 error bits latched", d, 32'h5);
        rd(12'h018, d); chk("R7 empty after last pop", d, 32'h90);
        rd(12'h000, d); chk("R7 empty read returns 0", d, 32'h0);
        rd(12'h004, d); chk("R7 empty read keeps status", d, 32'h5);
        wr(1, 32'h0);
        rd(12'h004, d); chk("R8 status cleared", d, 32'h0);
    endtask

    task automatic t_fifo16();
        logic [31:0] d;
        wr(11, 32'h10);
        for (int i = 0; i < 16; i++) push({4'(i), 8'(i * 7 + 1)});
        chk("R5 ready low at 16", 32'(rx_ready), 32'h0);
        rd(12'h018, d); chk("R5 full at 16", d, 32'hC0);
        push(12'hFEE);
        for (int i = 0; i < 16; i++) begin
            rd(12'h000, d);
            chk($sformatf("R5 order %0d", i), d, 32'({4'(i), 8'(i * 7 + 1)}));
            if (i == 0) begin
                rd(12'h018, d); chk("R7 full cleared by pop", d, 32'h80);
            end
        end
        rd(12'h004, d); chk("R8 last error bits", d, 32'hF);
        rd(12'h018, d); chk("R5 empty after drain", d, 32'h90);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        wr(0, 32'h1C3);
        chk("R4 tx_valid pulse", 32'(tx_valid), 32'h1);
        chk("R4 tx_byte", 32'(tx_byte), 32'hC3);
        @(negedge clk);
        chk("R4 single cycle", 32'(tx_valid), 32'h0);
        rd(12'h03C, d); chk("R4 raw tx bit", d, 32'h20);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(14, 32'h10);
        chk("R10 irq low, rx not raised", 32'(irq), 32'h0);
        push(12'h041);
        rd(12'h03C, d); chk("R9 raw rx set", d, 32'h30);
        rd(12'h040, d); chk("R10 masked", d, 32'h10);
        chk("R10 irq high", 32'(irq), 32'h1);
        push(12'h042);
        rd(12'h000, d); chk("R9 first pop word", d, 32'h41);
        rd(12'h03C, d); chk("R9 rx held above trigger", d, 32'h30);
        rd(12'h000, d); chk("R9 second pop word", d, 32'h42);
        rd(12'h03C, d); chk("R9 rx cleared at trigger-1", d, 32'h20);
        chk("R10 irq low after drain", 32'(irq), 32'h0);
        wr(14, 32'h20);
        chk("R10 irq from tx", 32'(irq), 32'h1);
        wr(14, 32'h0);
        chk("R10 irq masked off", 32'(irq), 32'h0);
    endtask

    task automatic t_flush();
        logic [31:0] d;
        push(12'h101); push(12'h102); push(12'h103);
        wr(11, 32'h10);
        rd(12'h018, d); chk("R11 no flush on same mode", d, 32'h80);
        wr(11, 32'h00);
        rd(12'h018, d); chk("R11 flush flags", d, 32'h90);
        rd(12'h03C, d); chk("R11 flush clears rx int", d, 32'h20);
        rd(12'h000, d); chk("R11 flushed buffer reads 0", d, 32'h0);
        push(12'h377);
        rd(12'h000, d); chk("R6 word after flush", d, 32'h377);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_id();
        t_single();
        t_fifo16();
        t_tx();
        t_irq();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule